// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words of nine bits go in on the write clock and come out, in the order written, on the read clock. Storage depth is a power of two set by a parameter, between 256 and 8192 words. Four active-low status outputs report the fill level: empty and almost-empty in the read domain, full and almost-full in the write domain.

The two almost thresholds come from a pair of 16-bit offset registers. A single active-low load strobe redirects the ordinary data ports to these registers. While the strobe is low, each enabled write stores one byte from `din[7:0]`, and each enabled read presents one byte on `dout[7:0]`. A four-state sequencer (states `SEQ_EMPTY_LO` → `SEQ_EMPTY_HI` → `SEQ_FULL_LO` → `SEQ_FULL_HI` → back to `SEQ_EMPTY_LO`, advanced by the `step` transition on each enabled load or readback access) sets the byte order. Each clock domain holds its own sequencer. Offsets are meant to be changed while the FIFO is idle.

Each side has two enables, and both must be high for an access. An output-enable input qualifies the data output.

Top module: `dcf_progflag_fifo`

## Requirements
- R1: A data write takes place only on a `wclk` edge where `wr_en_a`, `wr_en_b` and `ld_n` are all high and the FIFO is not full. If either enable is low, the write and the offset sequence are both blocked.
- R2: A data read takes place only on an `rclk` edge where `rd_en_a`, `rd_en_b` and `ld_n` are all high and `empty_n` is high. The word appears on `dout` after that edge. A read attempted while empty, or with either enable low, leaves `dout` and the read pointer unchanged.
- R3: `full_n` is low exactly when the occupancy equals the depth. While it is low, data writes are ignored.
- R4: `afull_n` is low exactly when the occupancy plus the full offset is at least the depth.
- R5: `aempty_n` is low exactly when the occupancy is at most the empty offset. It is high from occupancy offset+1 upwards, including the case where the offset is 0.
- R6: `empty_n` is low exactly when the occupancy is 0. A write into an empty FIFO raises `empty_n` within three `rclk` edges.
- R7: When `ld_n` is low and both write enables are high, each `wclk` edge stores `din[7:0]` into the next byte, in this order: empty offset bits 7:0, empty offset bits 15:8, full offset bits 7:0, full offset bits 15:8. After the fourth byte the sequence wraps to the first.
- R8: When `ld_n` is low and both read enables are high, each `rclk` edge presents the next offset byte on `dout[7:0]` in the R7 order, with `dout[8]` = 0. The sequence wraps after four bytes.
- R9: After reset the FIFO is empty, with `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. Both offsets are 7, both byte sequences start at the first byte, and the output register is 0.
- R10: When `out_en` is low, `dout` is all zeros and `dout_vld` is low. When `out_en` is high, `dout_vld` is high and `dout` shows the output register.
- R11: Words leave the FIFO in the order they were written, and their values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| ld_n | input | 1 | Offset access strobe, active low |
| out_en | input | 1 | Output qualifier |
| din | input | 9 | Write data; bits 7:0 carry offset bytes during load |
| dout | output | 9 | Read data or offset byte |
| dout_vld | output | 1 | High when dout is driven |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when at or below empty offset (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when within full offset of depth (write domain) |

## Verification
The main sweep fills the default 256-word FIFO one word at a time and then drains it one word at a time. After each step the bench lets the pointers settle and compares all four flags with values computed from the occupancy and the programmed offsets. This covers every threshold crossing in both directions. The stored words follow a multiplicative pattern, so a dropped, repeated or reordered word shows up during the drain. A write attempted while full is also caught there.

Single-enable writes and reads are tried separately from fully enabled ones, which separates the gating of each enable from the flag logic. Offset traffic is checked with distinct byte values in every position and read back over two full rounds, which exposes a wrong byte order and a missing wrap. A zero empty offset covers the boundary of the almost-empty comparison.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Byte position of the offset load / readback sequence
    typedef enum logic [1:0] {
        SEQ_EMPTY_LO = 2'd0,
        SEQ_EMPTY_HI = 2'd1,
        SEQ_FULL_LO  = 2'd2,
        SEQ_FULL_HI  = 2'd3
    } ofs_seq_t;

    localparam int OFS_W     = 16;
    localparam int OFS_RESET = 7;

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/dcf_ofs_seq.sv
module dcf_ofs_seq
    import dcf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_seq_t sel
);
    ofs_seq_t state_q;
    ofs_seq_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_EMPTY_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and output logic
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SEQ_EMPTY_LO: state_d = SEQ_EMPTY_HI;
                SEQ_EMPTY_HI: state_d = SEQ_FULL_LO;
                SEQ_FULL_LO:  state_d = SEQ_FULL_HI;
                SEQ_FULL_HI:  state_d = SEQ_EMPTY_LO;
            endcase
        end
        sel = state_q;
    end

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state_q != $past(state_q)));

    // R7
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              full_n,
    output logic              afull_n,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SUM_W = OFS_W + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [PW-1:0]    wptr_bin;
    logic [PW-1:0]    rptr_bin;
    logic [PW-1:0]    wcount;
    logic [SUM_W-1:0] fill_sum;
    logic             both_en;
    logic             data_we;
    logic             load_we;
    ofs_seq_t         ofs_sel;

    assign both_en = wr_en_a && wr_en_b;
    assign data_we = both_en && ld_n && full_n;
    assign load_we = both_en && !ld_n;

    assign rptr_bin = from_gray(rgray_sync);
    assign wcount   = wptr_bin - rptr_bin;
    assign fill_sum = SUM_W'(wcount) + SUM_W'(full_ofs);
    assign full_n   = (wcount != PW'(DEPTH));
    assign afull_n  = (fill_sum < SUM_W'(DEPTH));

    assign mem_we    = data_we;
    assign mem_waddr = wptr_bin[ADDR_W-1:0];
    assign mem_wdata = din;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_bin <= '0;
            wgray    <= '0;
        end else if (data_we) begin
            wptr_bin <= wptr_bin + 1'b1;
            wgray    <= to_gray(wptr_bin + 1'b1);
        end
    end

    dcf_ofs_seq u_seq (
        .clk   (wclk),
        .rst_n (rst_n),
        .step  (load_we),
        .sel   (ofs_sel)
    );

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            empty_ofs <= OFS_W'(OFS_RESET);
            full_ofs  <= OFS_W'(OFS_RESET);
        end else if (load_we) begin
            unique case (ofs_sel)
                SEQ_EMPTY_LO: empty_ofs[7:0]  <= din[7:0];
                SEQ_EMPTY_HI: empty_ofs[15:8] <= din[7:0];
                SEQ_FULL_LO:  full_ofs[7:0]   <= din[7:0];
                SEQ_FULL_HI:  full_ofs[15:8]  <= din[7:0];
            endcase
        end
    end

    // R1
    wr_gate_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !(wr_en_a && wr_en_b) |=> $stable(wptr_bin) && $stable(empty_ofs) && $stable(full_ofs));

    // R3
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && ld_n && wr_en_a && wr_en_b) |=> $stable(wptr_bin));

    // R3
    occupancy_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wcount <= PW'(DEPTH));

    // R4
    afull_before_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R6
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              ld_n,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] q_reg,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [PW-1:0] rptr_bin;
    logic [PW-1:0] wptr_bin;
    logic [PW-1:0] rcount;
    logic          both_en;
    logic          data_re;
    logic          peek_re;
    logic [7:0]    peek_byte;
    ofs_seq_t      ofs_sel;

    assign both_en = rd_en_a && rd_en_b;
    assign data_re = both_en && ld_n && empty_n;
    assign peek_re = both_en && !ld_n;

    assign wptr_bin  = from_gray(wgray_sync);
    assign rcount    = wptr_bin - rptr_bin;
    assign empty_n   = (rcount != '0);
    assign aempty_n  = (OFS_W'(rcount) > empty_ofs);
    assign mem_raddr = rptr_bin[ADDR_W-1:0];

    dcf_ofs_seq u_seq (
        .clk   (rclk),
        .rst_n (rst_n),
        .step  (peek_re),
        .sel   (ofs_sel)
    );

    always_comb begin
        unique case (ofs_sel)
            SEQ_EMPTY_LO: peek_byte = empty_ofs[7:0];
            SEQ_EMPTY_HI: peek_byte = empty_ofs[15:8];
            SEQ_FULL_LO:  peek_byte = full_ofs[7:0];
            SEQ_FULL_HI:  peek_byte = full_ofs[15:8];
        endcase
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_bin <= '0;
            rgray    <= '0;
        end else if (data_re) begin
            rptr_bin <= rptr_bin + 1'b1;
            rgray    <= to_gray(rptr_bin + 1'b1);
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            q_reg <= '0;
        end else if (data_re) begin
            q_reg <= mem_rdata;
        end else if (peek_re) begin
            q_reg <= DATA_W'(peek_byte);
        end
    end

    // R2
    rd_gate_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !(rd_en_a && rd_en_b) |=> $stable(rptr_bin) && $stable(q_reg));

    // R2
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && ld_n && rd_en_a && rd_en_b) |=> $stable(rptr_bin) && $stable(q_reg));

    // R5
    flag_order_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R8
    peek_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!ld_n && rd_en_a && rd_en_b) |=> $stable(rptr_bin) && (q_reg[DATA_W-1:8] == '0));
endmodule

// File: rtl/dcf_progflag_fifo.sv
module dcf_progflag_fifo
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              ld_n,
    input  logic              out_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              full_n,
    output logic              afull_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_rs;
    logic [PW-1:0]     rgray_ws;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] q_reg;
    logic [OFS_W-1:0]  empty_ofs;
    logic [OFS_W-1:0]  full_ofs;

    always_ff @(posedge wclk) begin
        if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_raddr];

    dcf_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .wclk       (wclk),
        .rst_n      (rst_n),
        .wr_en_a    (wr_en_a),
        .wr_en_b    (wr_en_b),
        .ld_n       (ld_n),
        .din        (din),
        .rgray_sync (rgray_ws),
        .wgray      (wgray),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .full_n     (full_n),
        .afull_n    (afull_n),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs)
    );

    dcf_gray_sync #(.W(PW)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    dcf_gray_sync #(.W(PW)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .rclk       (rclk),
        .rst_n      (rst_n),
        .rd_en_a    (rd_en_a),
        .rd_en_b    (rd_en_b),
        .ld_n       (ld_n),
        .wgray_sync (wgray_rs),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rgray      (rgray),
        .q_reg      (q_reg),
        .empty_n    (empty_n),
        .aempty_n   (aempty_n)
    );

    assign dout     = out_en ? q_reg : '0;
    assign dout_vld = out_en;

    // R10
    out_gate_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !out_en |-> (dout == '0) && !dout_vld);
endmodule

// File: tb/dcf_progflag_fifo_tb_top.sv
`timescale 1ns/100ps
module dcf_progflag_fifo_tb_top;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_a = 1'b0;
    logic       wr_en_b = 1'b0;
    logic       rd_en_a = 1'b0;
    logic       rd_en_b = 1'b0;
    logic       ld_n = 1'b1;
    logic       out_en = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_vld;
    logic       empty_n;
    logic       aempty_n;
    logic       full_n;
    logic       afull_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  e_ofs   = 7;
    int  f_ofs   = 7;

    always #2.0 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcf_progflag_fifo #(.ADDR_W(ADDR_W), .DATA_W(9)) dut_i (
        .wclk     (wclk),
        .rclk     (rclk),
        .rst_n    (rst_n),
        .wr_en_a  (wr_en_a),
        .wr_en_b  (wr_en_b),
        .rd_en_a  (rd_en_a),
        .rd_en_b  (rd_en_b),
        .ld_n     (ld_n),
        .out_en   (out_en),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld),
        .empty_n  (empty_n),
        .aempty_n (aempty_n),
        .full_n   (full_n),
        .afull_n  (afull_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] pattern(input int i);
        return 9'((i * 83 + 17) % 512);
    endfunction

    task automatic push_en(input logic a, input logic b, input logic [8:0] d);
        @(negedge wclk);
        din = d; wr_en_a = a; wr_en_b = b;
        @(negedge wclk);
        wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic pop_en(input logic a, input logic b, output logic [8:0] q);
        @(negedge rclk);
        rd_en_a = a; rd_en_b = b;
        @(negedge rclk);
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        q = dout;
    endtask

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (2) @(negedge wclk);
    endtask

    task automatic check_flags(input int c, input string tag);
        check({"R6 empty_n ", tag}, int'(empty_n), int'(c != 0));
        check({"R3 full_n ", tag}, int'(full_n), int'(c != DEPTH));
        check({"R4 afull_n ", tag}, int'(afull_n), int'(c + f_ofs < DEPTH));
        check({"R5 aempty_n ", tag}, int'(aempty_n), int'(c > e_ofs));
    endtask

    task automatic load_ofs(input int e, input int f);
        logic [7:0] bytes [4];
        bytes[0] = 8'(e); bytes[1] = 8'(e >> 8); bytes[2] = 8'(f); bytes[3] = 8'(f >> 8);
        @(negedge wclk);
        ld_n = 1'b0;
        for (int k = 0; k < 4; k++) push_en(1'b1, 1'b1, {1'b0, bytes[k]});
        ld_n = 1'b1;
        e_ofs = e; f_ofs = f;
        settle();
    endtask

    task automatic readback(input int rounds, input string tag);
        logic [8:0] q;
        int exp_b [4];
        exp_b[0] = e_ofs & 255; exp_b[1] = (e_ofs >> 8) & 255;
        exp_b[2] = f_ofs & 255; exp_b[3] = (f_ofs >> 8) & 255;
        @(negedge rclk);
        ld_n = 1'b0;
        for (int r = 0; r < rounds; r++) begin
            for (int k = 0; k < 4; k++) begin
                pop_en(1'b1, 1'b1, q);
                check({"R8 readback byte ", tag}, int'(q[7:0]), exp_b[k]);
                check({"R8 readback bit8 ", tag}, int'(q[8]), 0);
            end
        end
        ld_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] q;
        logic [8:0] prev;
        #23 rst_n = 1'b1;
        settle();

        // R9 reset state
        check("R9 empty_n", int'(empty_n), 0);
        check("R9 aempty_n", int'(aempty_n), 0);
        check("R9 full_n", int'(full_n), 1);
        check("R9 afull_n", int'(afull_n), 1);
        check("R9 dout", int'(dout), 0);
        check("R10 dout_vld high", int'(dout_vld), 1);
        readback(1, "R9 defaults");

        // R7 distinct bytes in every position, two rounds to see the wrap
        load_ofs(16'h1203, 16'h3405);
        readback(2, "R7 order");
        load_ofs(16'h0102, 16'h0304);
        readback(1, "R7 wrap reload");

        load_ofs(5, 9);

        // R1 single-enable writes are blocked
        push_en(1'b1, 1'b0, 9'h055);
        push_en(1'b0, 1'b1, 9'h0AA);
        settle();
        check("R1 blocked write empty_n", int'(empty_n), 0);

        // Fill sweep: R3 R4 R5 R6 at every occupancy
        for (int i = 0; i < DEPTH; i++) begin
            push_en(1'b1, 1'b1, pattern(i));
            settle();
            check_flags(i + 1, "fill");
        end

        // R3 write while full ignored
        push_en(1'b1, 1'b1, 9'h1AA);
        settle();
        check_flags(DEPTH, "overfull");

        // R2 single-enable read does not advance
        prev = dout;
        pop_en(1'b1, 1'b0, q);
        check("R2 gated read dout", int'(q), int'(prev));
        pop_en(1'b0, 1'b1, q);
        check("R2 gated read dout b", int'(q), int'(prev));
        settle();
        check("R2 gated read full_n", int'(full_n), 0);

        // Drain sweep: R11 order and flags on the way down
        for (int i = 0; i < DEPTH; i++) begin
            pop_en(1'b1, 1'b1, q);
            check("R11 data order", int'(q), int'(pattern(i)));
            settle();
            check_flags(DEPTH - i - 1, "drain");
        end

        // R2 read while empty ignored
        prev = dout;
        pop_en(1'b1, 1'b1, q);
        check("R2 empty read dout", int'(q), int'(prev));

        // R6 latency of empty flag after a write
        push_en(1'b1, 1'b1, 9'h123);
        repeat (3) @(negedge rclk);
        check("R6 empty_n within three rclk", int'(empty_n), 1);
        pop_en(1'b1, 1'b1, q);
        check("R11 single word", int'(q), 'h123);

        // R10 output qualifier
        @(negedge rclk);
        out_en = 1'b0;
        #1;
        check("R10 dout gated", int'(dout), 0);
        check("R10 dout_vld low", int'(dout_vld), 0);
        out_en = 1'b1;
        #1;
        check("R10 dout restored", int'(dout), 'h123);

        // R5 boundary with zero offsets
        settle();
        load_ofs(0, 0);
        check_flags(0, "zero ofs empty");
        push_en(1'b1, 1'b1, 9'h0F0);
        settle();
        check_flags(1, "zero ofs one word");
        pop_en(1'b1, 1'b1, q);
        check("R11 zero ofs word", int'(q), 'h0F0);
        settle();
        check_flags(0, "zero ofs drained");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule